// File: doc/BRIEF.md
# Interleaved Parity Read Checker

This block sits on the read-back path of a ternary match array. Each stored entry is 72 bits wide. The low 70 bits are payload. The two top bits hold parity for the payload, split into two interleaved lanes:

- bit 70 covers the even-indexed payload positions;
- bit 71 covers the odd-indexed payload positions.

Both lanes use even parity. When a read arrives with its valid strobe, the block registers the word and passes it on unchanged. In the same cycle it raises a single error flag if either lane's stored bit disagrees with its payload. A status bit arms this check, and the flag is held low when that bit is clear.

The block only detects errors. It never generates parity bits and never corrects data. A faulty word is still delivered in full, so the consumer decides what to do with it. Output data, output valid and the error flag all come out of one register stage, one cycle after the input strobe.

Top module: `rdParityChecker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid and parityErr are 0 and outData is all zeros.
- R2: One cycle after a cycle with rdValid high, outData equals the rdData of that cycle, bit for bit, whether or not parity is bad.
- R3: The even lane is the payload bits 0, 2, 4 … 68 together with bit 70. When the checker is enabled, parityErr is high one cycle after a read in which this lane's total count of ones is odd.
- R4: The odd lane is the payload bits 1, 3, 5 … 69 together with bit 71. When the checker is enabled, parityErr is high one cycle after a read in which this lane's total count of ones is odd.
- R5: parityErr is only ever high in a cycle where outValid is high. It is low in every other cycle.
- R6: When chkEnable is 0 during a read, parityErr is 0 in the following cycle, even if the parity is bad. The data is still delivered.
- R7: outValid is high in exactly the cycle after each cycle with rdValid high, and low otherwise.
- R8: When rdValid is low, outData keeps its previous value in the next cycle.
- R9: The flag depends only on each lane's parity. Two flips within one lane leave the flag low. One flip in each lane raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdData | input | 72 | Entry read from the array: payload in bits 69..0, even-lane parity in bit 70, odd-lane parity in bit 71 |
| rdValid | input | 1 | Qualifies rdData in this cycle |
| chkEnable | input | 1 | Status bit that arms the parity check |
| outData | output | 72 | Registered copy of the last valid read |
| outValid | output | 1 | Registered read valid |
| parityErr | output | 1 | Registered parity mismatch flag |

## Verification
The bench flips single bits at both ends of each lane: payload bit 0, payload bit 69, and each parity bit. A lane that is built with the wrong stride or the wrong parity bit misses one of these flips, or flags a clean word.

Two flips within one lane must leave the flag low, while one flip in each lane must raise it. A design that OR-combines the lanes with the wrong sense fails this pair.

Bad words read with the check disabled expose a flag that ignores the status bit. Idle cycles after an error expose a flag that is not cleared, and data that does not hold. Randomised reads then mix all of these cases.

// File: rtl/rpcPkg.sv
package rpcPkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic load;   // capture the incoming entry
    logic arm;    // evaluate and register the parity result
  } rdStrobe_t;
endpackage

// File: rtl/rpcControl.sv
module rpcControl
  import rpcPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdValid,
  input  logic      chkEnable,
  output rdStrobe_t strobe,
  output logic      validQ
);

  always_comb begin
    strobe.load = rdValid;
    strobe.arm  = rdValid & chkEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= rdValid;
  end

  // R7: output valid follows the input strobe by exactly one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> validQ);
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !validQ);

endmodule

// File: rtl/rpcDatapath.sv
module rpcDatapath
  import rpcPkg::*;
#(
  parameter int ENTRY_W = 72
) (
  input  logic               clk,
  input  logic               rstN,
  input  rdStrobe_t          strobe,
  input  logic [ENTRY_W-1:0] inData,
  output logic [ENTRY_W-1:0] dataQ,
  output logic               errQ
);

  localparam int PAY_W  = ENTRY_W - 2;
  localparam int EVEN_N = (PAY_W + 1) / 2;
  localparam int ODD_N  = PAY_W / 2;

  logic [EVEN_N-1:0] evenLane;
  logic [ODD_N-1:0]  oddLane;
  logic              evenBad;
  logic              oddBad;

  // Gather the interleaved lanes
  for (genvar i = 0; i < EVEN_N; i++) begin : g_even
    assign evenLane[i] = inData[2*i];
  end
  for (genvar j = 0; j < ODD_N; j++) begin : g_odd
    assign oddLane[j] = inData[2*j+1];
  end

  // Even parity: lane xor including its stored bit must be zero
  assign evenBad = (^evenLane) ^ inData[PAY_W];
  assign oddBad  = (^oddLane)  ^ inData[PAY_W+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (strobe.load) dataQ <= inData;
      errQ <= strobe.arm & (evenBad | oddBad);
    end
  end

  // R2: captured word is the one presented with the strobe
  a_r2_data_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> dataQ == $past(inData));
  // R8: no strobe, no change
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(dataQ));
  // R6: flag needs an armed check
  a_r6_unarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.arm |=> !errQ);

endmodule

// File: rtl/rdParityChecker.sv
module rdParityChecker
  import rpcPkg::*;
#(
  parameter int ENTRY_W = 72
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] rdData,
  input  logic               rdValid,
  input  logic               chkEnable,
  output logic [ENTRY_W-1:0] outData,
  output logic               outValid,
  output logic               parityErr
);

  rdStrobe_t strobe;

  rpcControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdValid   (rdValid),
    .chkEnable (chkEnable),
    .strobe    (strobe),
    .validQ    (outValid)
  );

  rpcDatapath #(.ENTRY_W(ENTRY_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inData (rdData),
    .dataQ  (outData),
    .errQ   (parityErr)
  );

  // R5: the flag only rides with a valid word
  a_r5_flag_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> outValid);
  // R6: disabled check never reports, seen at the ports
  a_r6_disabled_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !chkEnable) |=> !parityErr);

endmodule

// File: tb/rdParityChecker_test.sv
`timescale 1ns/1ps
module rdParityChecker_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [71:0] rdData;
  logic        rdValid;
  logic        chkEnable;
  logic [71:0] outData;
  logic        outValid;
  logic        parityErr;

  int checks = 0;
  int fails  = 0;
  logic [71:0] lastData;

  always #2.5 clk = ~clk;

  rdParityChecker uut (
    .clk(clk), .rstN(rstN), .rdData(rdData), .rdValid(rdValid),
    .chkEnable(chkEnable), .outData(outData), .outValid(outValid),
    .parityErr(parityErr)
  );

  // Build a clean word: even-lane bit at 70, odd-lane bit at 71
  function automatic logic [71:0] mkEntry(input logic [69:0] pay);
    logic pe = 1'b0, po = 1'b0;
    for (int i = 0; i < 70; i++) begin
      if (i % 2 == 0) pe ^= pay[i];
      else            po ^= pay[i];
    end
    return {po, pe, pay};
  endfunction

  function automatic logic badWord(input logic [71:0] w);
    int ce = 0, co = 0;
    for (int i = 0; i < 70; i++) begin
      if (i % 2 == 0) ce += w[i];
      else            co += w[i];
    end
    ce += w[70];
    co += w[71];
    return (ce % 2 != 0) || (co % 2 != 0);
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkD(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample just after the following rising edge
  task automatic doRead(input string tag, input logic [71:0] w, input logic v, input logic en);
    logic [71:0] expD;
    @(negedge clk);
    rdData = w; rdValid = v; chkEnable = en;
    expD = v ? w : lastData;
    @(posedge clk); #1;
    check1({tag, " R7 valid"}, outValid, v);
    check1({tag, " R5 flag"}, parityErr, v & en & badWord(w));
    checkD({tag, " R2/R8 data"}, outData, expD);
    lastData = expD;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [71:0] clean;
    logic [71:0] w;
    logic [69:0] pay;
    int unused;
    unused = $urandom(32'h5eed_1234);
    rstN = 1'b0; rdData = '0; rdValid = 1'b0; chkEnable = 1'b0;
    lastData = '0;
    repeat (3) @(posedge clk);
    #1;
    check1("R1 reset valid", outValid, 1'b0);
    check1("R1 reset flag", parityErr, 1'b0);
    checkD("R1 reset data", outData, '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check1("R1 post-reset valid", outValid, 1'b0);
    checkD("R1 post-reset data", outData, '0);

    clean = mkEntry({70{1'b1}});
    doRead("R3 R4 clean ones", clean, 1'b1, 1'b1);
    doRead("R3 zeros", mkEntry('0), 1'b1, 1'b1);
    doRead("R3 flip bit70", clean ^ (72'd1 << 70), 1'b1, 1'b1);
    doRead("R4 flip bit71", clean ^ (72'd1 << 71), 1'b1, 1'b1);
    doRead("R8 idle after error", '1, 1'b0, 1'b1);
    doRead("R3 flip pay0", clean ^ 72'd1, 1'b1, 1'b1);
    doRead("R4 flip pay69", clean ^ (72'd1 << 69), 1'b1, 1'b1);
    doRead("R9 two even flips", clean ^ 72'd5, 1'b1, 1'b1);
    check1("R9 two even flips quiet", parityErr, 1'b0);
    doRead("R9 two odd flips", clean ^ 72'ha, 1'b1, 1'b1);
    doRead("R9 one per lane", clean ^ 72'd3, 1'b1, 1'b1);
    check1("R9 one per lane flagged", parityErr, 1'b1);
    doRead("R6 disabled bad", clean ^ 72'd1, 1'b1, 1'b0);
    check1("R6 disabled quiet", parityErr, 1'b0);
    doRead("R8 hold", clean, 1'b0, 1'b0);
    doRead("R5 back-to-back bad", clean ^ (72'd1 << 70), 1'b1, 1'b1);
    doRead("R5 back-to-back good", clean, 1'b1, 1'b1);

    for (int n = 0; n < 400; n++) begin
      pay = {$urandom, $urandom, $urandom};
      w = mkEntry(pay);
      if ($urandom % 3 == 0) w[$urandom % 72] ^= 1'b1;
      if ($urandom % 5 == 0) w[$urandom % 72] ^= 1'b1;
      doRead("R3 R4 R6 random", w, ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule